// File: doc/BRIEF.md
# DRAM Rank Refresh Sequencer

This block sequences periodic refresh for one DRAM rank. A down-counter measures the refresh interval. When it expires, the sequencer leaves normal operation and steps through a fixed order of phases:

- wait for in-flight accesses to finish;
- wake the rank if it sits in a power-down state;
- close any open banks;
- issue the refresh command;
- hold the rank busy for the refresh cycle time.

While any phase other than the resting phase is active, the rank is reported as unavailable to the command scheduler.

A power-state manager is connected to the block. The sequencer raises a wake-up request towards it and waits for its wake-up-done indication before continuing. The manager receives a one-cycle done pulse when the refresh cycle time ends.

If the manager has placed the rank in self-refresh by the time the refresh cycle ends, the sequencer enters a self-refresh exit phase. In that phase it requests wake-up, and once the exit completes it starts a new refresh sequence from the drain phase.

Top module: `refseq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, rank_avail_o is 1 and wake_req_o, pre_all_o, ref_o and ref_done_o are 0.
- R2: The drain phase (rank_avail_o low) begins trefi_i+2 cycles after reset release. It also begins trefi_i+2 cycles after each cycle in which ref_o was high, provided the sequencer has returned to rest by then.
- R3: In the drain phase the sequencer holds while no_pending_i is 0. It leaves on the clock edge at which no_pending_i is seen as 1.
- R4: In the cycle after the drain phase, wake_req_o is raised if pwr_state_i is 3 (precharge power-down) or 5 (active power-down). The sequencer then holds until wake_done_i is 1, and on that edge moves on. For any other power state, no wake-up is requested and the sequencer moves on at once.
- R5: When banks_open_i is 1 at the branch point, pre_all_o is high for exactly one cycle and ref_o follows in the next cycle. When banks_open_i is 0, no pre_all_o pulse occurs and ref_o comes directly.
- R6: ref_o is high for exactly one cycle. It is followed by exactly trfc_i cycles with rank_avail_o low before the rank returns to rest.
- R7: ref_done_o is high for exactly one cycle: the last cycle of the refresh cycle time.
- R8: If pwr_state_i is 2 (self-refresh) at the end of the refresh cycle time, the sequencer enters a self-refresh exit phase. There it holds wake_req_o high until wake_done_i is 1, then enters the drain phase and performs another refresh.
- R9: rank_avail_o is 0 in every phase other than rest and 1 at rest. At most one of pre_all_o, ref_o and ref_done_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trefi_i | input | TREFI_W | Refresh interval in cycles |
| trfc_i | input | TRFC_W | Refresh cycle time in cycles, at least 1 |
| no_pending_i | input | 1 | No accesses to this rank are in flight |
| banks_open_i | input | 1 | At least one bank of the rank is open |
| pwr_state_i | input | 3 | Rank power state: 0 idle, 1 refresh, 2 self-refresh, 3 precharge power-down, 4 active, 5 active power-down |
| wake_done_i | input | 1 | Power manager has completed a wake-up |
| wake_req_o | output | 1 | Request to wake the rank |
| pre_all_o | output | 1 | Precharge-all strobe |
| ref_o | output | 1 | Refresh command strobe |
| rank_avail_o | output | 1 | Rank may accept scheduled commands |
| ref_done_o | output | 1 | One-cycle pulse at the end of the refresh cycle time |

## Verification
Every output is registered state decoded without further delay. A result is therefore due a fixed number of edges after its cause:

| Result | Due |
|---|---|
| Drain entry | trefi_i+2 samples after reset release or after the ref_o sample |
| ref_o | 2 or 3 samples after drain entry, depending on banks_open_i |
| ref_done_o | trfc_i samples after ref_o |
| Rest | 1 sample after ref_done_o |

The bench samples on the falling edge. It counts falling edges from the triggering sample to the first sample showing the result, and compares that count with the formula above.

Holds are checked by observing several samples in which the awaited strobe stays absent:

- drain while accesses are pending;
- wake-up not yet acknowledged;
- self-refresh exit.

Each hold is then released, and the remaining latency is checked.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
  typedef enum logic [2:0] {
    RS_IDLE      = 3'd0,
    RS_DRAIN     = 3'd1,
    RS_PD_EXIT   = 3'd2,
    RS_SREF_EXIT = 3'd3,
    RS_PRE       = 3'd4,
    RS_START     = 3'd5,
    RS_RUN       = 3'd6
  } ref_state_e;

  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_REF     = 3'd1,
    PS_SREF    = 3'd2,
    PS_PRE_PDN = 3'd3,
    PS_ACT     = 3'd4,
    PS_ACT_PDN = 3'd5
  } pwr_state_e;

  function automatic logic is_powered_down(logic [2:0] ps);
    return (ps == 3'(PS_PRE_PDN)) || (ps == 3'(PS_ACT_PDN));
  endfunction
endpackage

// File: rtl/refseq_interval.sv
module refseq_interval #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reload_i,
  input  logic [CW-1:0] trefi_i,
  output logic          due_o
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  // first load after reset, then reload on each refresh strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q || reload_i) begin
      cnt_q   <= trefi_i;
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign due_o = armed_q && (cnt_q == '0);

  a_r2_reload_clears_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && trefi_i != '0) |=> !due_o);
endmodule

// File: rtl/refseq_rfc_timer.sv
module refseq_rfc_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          run_i,
  input  logic [CW-1:0] trfc_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= (trfc_i == '0) ? '0 : trfc_i - 1'b1;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = (cnt_q == '0);

  a_r6_no_early_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && trfc_i > CW'(1)) |=> !expire_o);
endmodule

// File: rtl/refseq_fsm.sv
module refseq_fsm
  import refseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       due_i,
  input  logic       no_pending_i,
  input  logic       banks_open_i,
  input  logic [2:0] pwr_state_i,
  input  logic       wake_done_i,
  input  logic       rfc_expire_i,
  output logic       wake_req_o,
  output logic       pre_all_o,
  output logic       ref_o,
  output logic       run_o,
  output logic       avail_o,
  output logic       done_o
);
  ref_state_e state_q, state_d;
  logic       pd;

  assign pd = is_powered_down(pwr_state_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE:      if (due_i) state_d = RS_DRAIN;
      RS_DRAIN:     if (no_pending_i) state_d = RS_PD_EXIT;
      RS_PD_EXIT:   if (!pd || wake_done_i) state_d = banks_open_i ? RS_PRE : RS_START;
      RS_SREF_EXIT: if (wake_done_i) state_d = RS_DRAIN;
      RS_PRE:       state_d = RS_START;
      RS_START:     state_d = RS_RUN;
      RS_RUN:       if (rfc_expire_i)
                      state_d = (pwr_state_i == 3'(PS_SREF)) ? RS_SREF_EXIT : RS_IDLE;
      default:      state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RS_IDLE;
    else         state_q <= state_d;
  end

  assign wake_req_o = (state_q == RS_SREF_EXIT) || (state_q == RS_PD_EXIT && pd);
  assign pre_all_o  = (state_q == RS_PRE);
  assign ref_o      = (state_q == RS_START);
  assign run_o      = (state_q == RS_RUN);
  assign avail_o    = (state_q == RS_IDLE);
  assign done_o     = (state_q == RS_RUN) && rfc_expire_i;

  a_r3_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_DRAIN && !no_pending_i) |=> state_q == RS_DRAIN);
  a_r8_sref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_SREF_EXIT && !wake_done_i) |=> wake_req_o);
  a_r8_sref_to_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RS_SREF_EXIT && wake_done_i) |=> state_q == RS_DRAIN);
  a_r7_done_to_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pwr_state_i != 3'(PS_SREF)) |=> avail_o);
  a_r2_idle_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !due_i) |=> avail_o);
endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl #(
  parameter int unsigned TREFI_W = 16,
  parameter int unsigned TRFC_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TREFI_W-1:0] trefi_i,
  input  logic [TRFC_W-1:0]  trfc_i,
  input  logic               no_pending_i,
  input  logic               banks_open_i,
  input  logic [2:0]         pwr_state_i,
  input  logic               wake_done_i,
  output logic               wake_req_o,
  output logic               pre_all_o,
  output logic               ref_o,
  output logic               rank_avail_o,
  output logic               ref_done_o
);
  logic due, rfc_expire, rfc_run;

  refseq_interval #(.CW(TREFI_W)) u_interval (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(ref_o),
    .trefi_i (trefi_i),
    .due_o   (due)
  );

  refseq_rfc_timer #(.CW(TRFC_W)) u_rfc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ref_o),
    .run_i   (rfc_run),
    .trfc_i  (trfc_i),
    .expire_o(rfc_expire)
  );

  refseq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .due_i       (due),
    .no_pending_i(no_pending_i),
    .banks_open_i(banks_open_i),
    .pwr_state_i (pwr_state_i),
    .wake_done_i (wake_done_i),
    .rfc_expire_i(rfc_expire),
    .wake_req_o  (wake_req_o),
    .pre_all_o   (pre_all_o),
    .ref_o       (ref_o),
    .run_o       (rfc_run),
    .avail_o     (rank_avail_o),
    .done_o      (ref_done_o)
  );

  a_r9_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_all_o, ref_o, ref_done_o}));
  a_r5_pre_then_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |=> ref_o);
  a_r6_ref_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> (!ref_o && !rank_avail_o));
  a_r9_busy_when_strobing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_all_o || ref_o || wake_req_o) |-> !rank_avail_o);
endmodule

// File: tb/refseq_ctrl_tb.sv
module refseq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trefi = 16'd4;
  logic [9:0]  trfc = 10'd2;
  logic        no_pend = 1'b1;
  logic        banks = 1'b0;
  logic [2:0]  pwr = 3'd4;
  logic        wdone = 1'b0;
  logic        wreq, pre, refc, avail, rdone;

  int n_chk = 0;
  int n_bad = 0;
  int pre_cnt = 0;
  int ref_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  refseq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trefi_i(trefi), .trfc_i(trfc),
    .no_pending_i(no_pend), .banks_open_i(banks), .pwr_state_i(pwr),
    .wake_done_i(wdone), .wake_req_o(wreq), .pre_all_o(pre), .ref_o(refc),
    .rank_avail_o(avail), .ref_done_o(rdone)
  );

  always @(negedge clk) begin
    if (pre)  pre_cnt++;
    if (refc) ref_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 avail low, 1 pre, 2 ref, 3 done, 4 avail high, 5 wake req
  function automatic bit sel(input int which);
    case (which)
      0: return !avail;
      1: return pre;
      2: return refc;
      3: return rdone;
      4: return avail;
      default: return wreq;
    endcase
  endfunction

  task automatic wait_ev(input int which, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!sel(which) && cnt < 2000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(avail && !wreq && !pre && !refc && !rdone, "R1", avail, 1);
    rst_n = 1'b1;
  endtask

  initial begin
    int c, p0, r0;
    // sweep of interval, cycle time and bank state
    for (int t = 3; t <= 8; t += 5) begin
      for (int r = 1; r <= 3; r++) begin
        for (int b = 0; b < 2; b++) begin
          trefi = 16'(t); trfc = 10'(r); banks = b[0]; pwr = 3'd4; no_pend = 1'b1;
          do_reset();
          @(negedge clk);
          chk(avail && !refc, "R1", avail, 1);
          c = 1;
          begin int k; wait_ev(0, k); c += k; end
          chk(c == t + 2, "R2", c, t + 2);
          p0 = pre_cnt; r0 = ref_cnt;
          wait_ev(2, c);
          chk(c == 2 + b, "R5", c, 2 + b);
          chk(pre_cnt - p0 == b, "R5", pre_cnt - p0, b);
          wait_ev(3, c);
          chk(c == r, "R7", c, r);
          chk(!avail, "R6", avail, 0);
          @(negedge clk);
          chk(avail && !rdone, "R6", avail, 1);
          chk(ref_cnt - r0 == 1, "R6", ref_cnt - r0, 1);
          wait_ev(0, c);
          chk(c == t + 1 - r, "R2", c, t + 1 - r);
        end
      end
    end

    // drain hold
    trefi = 16'd4; trfc = 10'd2; banks = 1'b0; pwr = 3'd4; no_pend = 1'b0;
    do_reset();
    wait_ev(0, c);
    r0 = ref_cnt;
    repeat (5) @(negedge clk);
    chk(!avail && ref_cnt == r0, "R3", ref_cnt - r0, 0);
    no_pend = 1'b1;
    wait_ev(2, c);
    chk(c == 2, "R3", c, 2);

    // power-down wake-up, both power-down kinds
    for (int m = 0; m < 2; m++) begin
      banks = m[0]; pwr = (m == 0) ? 3'd3 : 3'd5; no_pend = 1'b1;
      do_reset();
      wait_ev(0, c);
      wait_ev(5, c);
      chk(c == 1, "R4", c, 1);
      r0 = ref_cnt; p0 = pre_cnt;
      repeat (3) @(negedge clk);
      chk(wreq && ref_cnt == r0 && pre_cnt == p0, "R4", wreq, 1);
      wdone = 1'b1; pwr = 3'd4;
      @(negedge clk);
      wdone = 1'b0;
      chk(!wreq, "R4", wreq, 0);
      c = 1;
      if (!refc) begin int k; wait_ev(2, k); c += k; end
      chk(c == 1 + m, "R4", c, 1 + m);
    end

    // no wake request when active
    banks = 1'b0; pwr = 3'd4;
    do_reset();
    wait_ev(0, c);
    @(negedge clk);
    chk(!wreq, "R4", wreq, 0);

    // self-refresh exit after refresh
    trefi = 16'd6; trfc = 10'd3; banks = 1'b0; pwr = 3'd4;
    do_reset();
    wait_ev(2, c);
    pwr = 3'd2;
    wait_ev(3, c);
    chk(c == 3, "R8", c, 3);
    @(negedge clk);
    chk(wreq && !avail, "R8", wreq, 1);
    r0 = ref_cnt;
    repeat (4) @(negedge clk);
    chk(wreq && ref_cnt == r0 && !avail, "R8", ref_cnt - r0, 0);
    wdone = 1'b1; pwr = 3'd4;
    @(negedge clk);
    wdone = 1'b0;
    chk(!wreq && !avail, "R9", avail, 0);
    wait_ev(2, c);
    chk(c == 2, "R8", c, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule